// File: doc/BRIEF.md
# Burst Address Sequencer

The sequencer produces one memory address per clock for a burst of up to four beats. A base address is captured from the external address bus when either of two address strobes is raised while the chip enable is high. After that cycle, the address is built internally and moves to the next beat only in cycles where the advance input is high. A new base address can be captured on any cycle, so a system that never uses bursts can present a fresh address every clock.

Only the low beat field is changed by the sequencer. The upper address bits pass through unchanged from the captured base. A static order input picks one of two beat orders. The wrapping order adds the beat count to the captured low bits, modulo four. The interleaved order XORs the beat count into them. A zero on the order input selects interleaved order, so tying the input low gives the default.

The address output comes from registers. It shows the effect of a strobe or advance one clock after that strobe or advance is sampled.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is low and in the first cycle after it, addr_out is all zeros.
- R2: When strb_a is 1 and chip_en is 1 at a clock edge, addr_out equals the ext_addr sampled at that edge from the following cycle on.
- R3: When strb_b is 1 and chip_en is 1 at a clock edge, addr_out equals the ext_addr sampled at that edge from the following cycle on.
- R4: When chip_en is 0, both strobes have no effect: with adv low, addr_out keeps its value.
- R5: With order_lin = 1 (wrapping order), each accepted advance adds 1, modulo 4, to addr_out bits [1:0].
- R6: With order_lin = 0 (interleaved order), addr_out bits [1:0] equal the captured low bits XOR the number of advances since the capture (0..3).
- R7: An advance never changes addr_out bits above bit 1.
- R8: With no accepted strobe and adv low, addr_out holds its value.
- R9: When an accepted strobe and adv are high in the same cycle, the strobe wins: addr_out becomes ext_addr with beat count zero.
- R10: After four advances the beat count wraps, and addr_out returns to the captured base address in both orders.
- R11: Strobes on consecutive cycles capture a new base address every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chip_en | input | 1 | Qualifies both address strobes |
| strb_a | input | 1 | First address strobe |
| strb_b | input | 1 | Second address strobe |
| adv | input | 1 | Step to the next beat |
| order_lin | input | 1 | 1 = wrapping order, 0 = interleaved order |
| ext_addr | input | ADDR_W | External address captured at a strobe |
| addr_out | output | ADDR_W | Address for the current beat |

## Verification
The assertions assume that order_lin stays constant during a burst. Every hold and step property therefore allows an order change in its consequent. The stimulus sets order_lin only in cycles where a strobe captures a new base. The properties also assume ADDR_W is larger than the beat field, and the bench uses the default widths to meet this. Strobes, advances and the chip enable are driven on the falling edge only, so each rising edge samples one well-defined command.

// File: rtl/burst_pkg.sv
package burst_pkg;
  // Beat-order encoding, as seen on the order_lin pin.
  typedef enum logic {
    ORD_XOR  = 1'b0,
    ORD_WRAP = 1'b1
  } order_e;

  // One decoded command for a cycle.
  typedef struct packed {
    logic load;
    logic step;
  } burst_cmd_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic       chip_en,
  input  logic       strb_a,
  input  logic       strb_b,
  input  logic       adv,
  output burst_cmd_t cmd
);
  logic any_strobe;

  always_comb begin
    any_strobe = strb_a | strb_b;
    cmd.load   = chip_en & any_strobe;
    // A capture outranks an advance in the same cycle.
    cmd.step   = adv & ~cmd.load;
  end
endmodule

// File: rtl/beat_ctr.sv
module beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  output logic [BEAT_W-1:0] beat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    beat <= '0;
    else if (load) beat <= '0;
    else if (step) beat <= beat + 1'b1;
  end
endmodule

// File: rtl/base_hold.sv
module base_hold #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] base
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    base <= '0;
    else if (load) base <= ext_addr;
  end
endmodule

// File: rtl/addr_mix.sv
module addr_mix
  import burst_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [BEAT_W-1:0] beat,
  input  logic              order_lin,
  output logic [ADDR_W-1:0] addr
);
  localparam int HI_W = ADDR_W - BEAT_W;

  function automatic logic [BEAT_W-1:0] mix_low(
    input logic [BEAT_W-1:0] lo,
    input logic [BEAT_W-1:0] n,
    input order_e            ord
  );
    if (ord == ORD_WRAP) mix_low = lo + n;
    else                 mix_low = lo ^ n;
  endfunction

  logic [BEAT_W-1:0] low_q;
  order_e            ord;

  always_comb begin
    ord   = order_e'(order_lin);
    low_q = mix_low(base[BEAT_W-1:0], beat, ord);
    addr  = {base[ADDR_W-1:BEAT_W], low_q};
  end

  if (HI_W < 1) begin : g_bad_width
    initial $error("ADDR_W must exceed BEAT_W");
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic              strb_a,
  input  logic              strb_b,
  input  logic              adv,
  input  logic              order_lin,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] addr_out
);
  burst_cmd_t        cmd;
  logic              load_evt;
  logic              step_evt;
  logic [BEAT_W-1:0] beat;
  logic [ADDR_W-1:0] base;

  burst_ctrl u_ctrl (
    .chip_en (chip_en),
    .strb_a  (strb_a),
    .strb_b  (strb_b),
    .adv     (adv),
    .cmd     (cmd)
  );

  // Named event wires for the checker.
  assign load_evt = cmd.load;
  assign step_evt = cmd.step;

  beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_evt),
    .step  (step_evt),
    .beat  (beat)
  );

  base_hold #(.ADDR_W(ADDR_W)) u_base (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_evt),
    .ext_addr (ext_addr),
    .base     (base)
  );

  addr_mix #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_mix (
    .base      (base),
    .beat      (beat),
    .order_lin (order_lin),
    .addr      (addr_out)
  );
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chip_en,
  input logic              adv,
  input logic              order_lin,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [ADDR_W-1:0] addr_out,
  input logic              load_evt,
  input logic              step_evt
);
  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (addr_out == $past(ext_addr)));

  // R4
  gated_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_en && !adv) |=> (addr_out == $past(addr_out)) || (order_lin != $past(order_lin)));

  // R5
  wrap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && order_lin) |=>
      (addr_out[BEAT_W-1:0] == BEAT_W'($past(addr_out[BEAT_W-1:0]) + 1'b1)) || !order_lin);

  // R7
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> (addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W])));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && !adv) |=> (addr_out == $past(addr_out)) || (order_lin != $past(order_lin)));

  // R9
  strobe_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && adv) |=> (addr_out == $past(ext_addr)));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .chip_en   (chip_en),
  .adv       (adv),
  .order_lin (order_lin),
  .ext_addr  (ext_addr),
  .addr_out  (addr_out),
  .load_evt  (load_evt),
  .step_evt  (step_evt)
);

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          chip_en = 1'b0, strb_a = 1'b0, strb_b = 1'b0, adv = 1'b0, order_lin = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] addr_out;
  int            total = 0;
  int            bad = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .BEAT_W(2)) u_burst_addr_gen (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .strb_a(strb_a), .strb_b(strb_b),
    .adv(adv), .order_lin(order_lin), .ext_addr(ext_addr), .addr_out(addr_out)
  );

  // Independent model of a beat address.
  function automatic logic [AW-1:0] expect_addr(logic [AW-1:0] b, int k, bit lin);
    logic [1:0] lo;
    lo = lin ? 2'((int'(b[1:0]) + k) % 4) : (b[1:0] ^ 2'(k % 4));
    return {b[AW-1:2], lo};
  endfunction

  task automatic check(string req, logic [AW-1:0] exp);
    total++;
    if (addr_out !== exp) begin
      bad++;
      $display("FAIL %s: got %h want %h", req, addr_out, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    strb_a = 0; strb_b = 0; adv = 0; chip_en = 1;
  endtask

  task automatic capture(logic [AW-1:0] a, bit use_b, bit lin);
    quiet(); ext_addr = a; order_lin = lin;
    if (use_b) strb_b = 1; else strb_a = 1;
    tick(); quiet(); ext_addr = '0;
  endtask

  task automatic t_reset();
    ext_addr = 20'hABCDE; chip_en = 1; strb_a = 1;
    #5 check("R1", '0);
    @(negedge clk); rst_n = 1; quiet();
    tick(); check("R1", '0);
  endtask

  task automatic t_strobe_a();
    capture(20'h12345, 0, 1); check("R2", 20'h12345);
  endtask

  task automatic t_strobe_b();
    capture(20'h5A5A6, 1, 1); check("R3", 20'h5A5A6);
  endtask

  task automatic t_gated();
    capture(20'h11111, 0, 1);
    chip_en = 0; strb_a = 1; strb_b = 1; ext_addr = 20'hFFFFF;
    tick(); check("R4", 20'h11111);
    quiet();
  endtask

  task automatic t_wrap_burst();
    logic [AW-1:0] b = 20'hC0F02;
    capture(b, 0, 1);
    for (int k = 1; k <= 4; k++) begin
      adv = 1; tick(); adv = 0;
      check(k == 4 ? "R10" : "R5", expect_addr(b, k, 1));
      check("R7", {b[AW-1:2], addr_out[1:0]});
    end
  endtask

  task automatic t_xor_burst();
    logic [AW-1:0] b = 20'h3ACE3;
    capture(b, 1, 0);
    for (int k = 1; k <= 4; k++) begin
      adv = 1; tick(); adv = 0;
      check(k == 4 ? "R10" : "R6", expect_addr(b, k, 0));
      check("R7", {b[AW-1:2], addr_out[1:0]});
    end
  endtask

  task automatic t_hold();
    logic [AW-1:0] b = 20'h00701;
    capture(b, 0, 0);
    adv = 1; tick(); adv = 0;
    for (int i = 0; i < 3; i++) begin
      tick(); check("R8", expect_addr(b, 1, 0));
    end
  endtask

  task automatic t_collide();
    capture(20'h40002, 0, 1);
    adv = 1; tick();
    ext_addr = 20'h77771; strb_b = 1; adv = 1;
    tick(); quiet(); check("R9", 20'h77771);
    adv = 1; tick(); adv = 0; check("R9", 20'h77772);
  endtask

  task automatic t_back2back();
    chip_en = 1;
    for (int i = 0; i < 5; i++) begin
      ext_addr = AW'(20'h10000 + i * 20'h01013); strb_a = (i % 2 == 0); strb_b = (i % 2 == 1);
      tick(); check("R11", AW'(20'h10000 + i * 20'h01013));
    end
    quiet();
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_strobe_a();
    t_strobe_b();
    t_gated();
    t_wrap_burst();
    t_xor_burst();
    t_hold();
    t_collide();
    t_back2back();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout want completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule